// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block receives message-signalled interrupts at a PCIe root port. Software programs a 64-bit doorbell address, a 32-bit enable word and a 32-bit mask word through a small 32-bit register port. Inbound memory writes arrive on a separate doorbell port. A write that lands on the programmed address with a full 4-byte strobe is taken as a doorbell. Its data is read as a vector number, and that number sets one bit of a 32-bit pending-status word. A single level interrupt goes toward the CPU.

The interrupt is raised only when a doorbell is taken and leaves an unmasked pending bit. It is dropped only when a status write leaves the whole status word at zero. Software clears pending bits by writing ones to toggle them. Changing the mask never re-evaluates the interrupt.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, the doorbell address, enable, mask and status registers read zero and `irq` is 0. A read of any offset other than 0x820, 0x824, 0x828, 0x82C or 0x830 returns zero.
- R2: A write to 0x820 replaces bits 31:0 of the doorbell address, and a write to 0x824 replaces bits 63:32. The other half is kept, and both halves read back at those offsets.
- R3: A write to 0x828 sets the enable word and a write to 0x82C sets the mask word. Each reads back as written.
- R4: A doorbell is taken only when `db_valid` is 1, `db_addr` equals the 64-bit doorbell address exactly, `db_be` is 4'b1111 and the enable word is nonzero. Any other doorbell write changes neither status nor `irq`.
- R5: A taken doorbell with data value v < 32 sets status bit v if enable bit v is 1. A value of 32 or more sets no bit.
- R6: On the clock edge that takes a doorbell, `irq` becomes 1 if (new status AND NOT mask) is nonzero. Otherwise `irq` keeps its value.
- R7: A write to 0x830 XORs the written word into status (0x830 reads status). If the result is zero and no doorbell raises `irq` on that edge, `irq` becomes 0. Otherwise `irq` is unchanged.
- R8: A write to the mask word does not by itself change `irq`, whether `irq` is high or low.
- R9: When a status write and a taken doorbell share a clock edge, the new status is (old status XOR written word) OR the doorbell bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| db_valid | input | 1 | Inbound doorbell write valid |
| db_addr | input | 64 | Inbound write address |
| db_data | input | 32 | Inbound write data, taken as vector number |
| db_be | input | 4 | Inbound byte strobes |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
On every cycle, the assertions check the following. `irq` may rise only after a taken doorbell, and may fall only after a status write that leaves status zero. No status bit appears without a doorbell or a status write. A mask-only write leaves `irq` stable, and the decoded doorbell vector has at most one bit set. Only the bench's scenarios can show the rest: the exact vector-to-bit mapping for every value from 0 to 39 under different enable and mask patterns, half-word address replacement, the rejection of near-miss addresses and partial strobes, and the combined status-write and doorbell ordering.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_DB_LO  = 12'h820;
  localparam logic [OFS_W-1:0] OFS_DB_HI  = 12'h824;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h828;
  localparam logic [OFS_W-1:0] OFS_MASK   = 12'h82C;
  localparam logic [OFS_W-1:0] OFS_STATUS = 12'h830;
endpackage

// File: rtl/msi_db_regs.sv
module msi_db_regs
  import msi_db_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   status,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*DATA_W-1:0] db_base,
  output logic [DATA_W-1:0]   enable,
  output logic [DATA_W-1:0]   mask,
  output logic                st_wr,
  output logic                mask_wr
);
  logic [DATA_W-1:0] base_lo_q, base_hi_q, en_q, mask_q;
  logic              lo_we, hi_we, en_we;

  always_comb begin
    lo_we   = reg_wr && (reg_addr == AW'(OFS_DB_LO));
    hi_we   = reg_wr && (reg_addr == AW'(OFS_DB_HI));
    en_we   = reg_wr && (reg_addr == AW'(OFS_ENABLE));
    mask_wr = reg_wr && (reg_addr == AW'(OFS_MASK));
    st_wr   = reg_wr && (reg_addr == AW'(OFS_STATUS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      en_q      <= '0;
      mask_q    <= '0;
    end else begin
      if (lo_we)   base_lo_q <= reg_wdata;
      if (hi_we)   base_hi_q <= reg_wdata;
      if (en_we)   en_q      <= reg_wdata;
      if (mask_wr) mask_q    <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      AW'(OFS_DB_LO):  reg_rdata = base_lo_q;
      AW'(OFS_DB_HI):  reg_rdata = base_hi_q;
      AW'(OFS_ENABLE): reg_rdata = en_q;
      AW'(OFS_MASK):   reg_rdata = mask_q;
      AW'(OFS_STATUS): reg_rdata = status;
      default:         reg_rdata = '0;
    endcase
  end

  assign db_base = {base_hi_q, base_lo_q};
  assign enable  = en_q;
  assign mask    = mask_q;

  assert_half_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (base_hi_q == $past(base_hi_q)));
endmodule

// File: rtl/msi_db_match.sv
module msi_db_match #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                db_valid,
  input  logic [2*DATA_W-1:0] db_addr,
  input  logic [DATA_W-1:0]   db_data,
  input  logic [3:0]          db_be,
  input  logic [2*DATA_W-1:0] db_base,
  input  logic [DATA_W-1:0]   enable,
  output logic                db_hit,
  output logic [DATA_W-1:0]   set_vec
);
  localparam int unsigned VEC_W = $clog2(DATA_W);

  logic in_range;

  always_comb begin
    db_hit   = db_valid && (db_addr == db_base) && (db_be == 4'b1111) && (|enable);
    in_range = (db_data >> VEC_W) == '0;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign set_vec[i] = db_hit && in_range && enable[i] &&
                        (db_data[VEC_W-1:0] == VEC_W'(i));
  end

  assert_onehot_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
  assert_no_set_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (set_vec == '0));
endmodule

// File: rtl/msi_db_status.sv
module msi_db_status #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              db_hit,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] st_q, st_d, toggle;
  logic              irq_q, irq_d, st_en, irq_en;

  always_comb begin
    toggle = st_wr ? wdata : '0;
    st_d   = (st_q ^ toggle) | set_vec;
    st_en  = st_wr || db_hit;
    irq_d  = irq_q;
    if (db_hit && (|(st_d & ~mask)))
      irq_d = 1'b1;
    else if (st_wr && (st_d == '0))
      irq_d = 1'b0;
    irq_en = st_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign status = st_q;
  assign irq    = irq_q;

  assert_irq_rise_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(db_hit));
  assert_irq_fall_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ($past(st_wr) && (st_q == '0)));
  assert_bits_need_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & ~$past(st_q))) |-> ($past(db_hit) || $past(st_wr)));
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                db_valid,
  input  logic [2*DATA_W-1:0] db_addr,
  input  logic [DATA_W-1:0]   db_data,
  input  logic [3:0]          db_be,
  output logic                irq
);
  localparam int unsigned DB_AW = 2 * DATA_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [DB_AW-1:0]  db_base;
  logic [DATA_W-1:0] enable, mask, status, set_vec;
  logic              st_wr, mask_wr, db_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  msi_db_regs #(.DATA_W(DATA_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .reg_rdata(reg_rdata),
    .db_base(db_base), .enable(enable), .mask(mask),
    .st_wr(st_wr), .mask_wr(mask_wr)
  );

  msi_db_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_sync_n), .db_valid(db_valid), .db_addr(db_addr),
    .db_data(db_data), .db_be(db_be), .db_base(db_base), .enable(enable),
    .db_hit(db_hit), .set_vec(set_vec)
  );

  msi_db_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_sync_n), .st_wr(st_wr), .wdata(reg_wdata),
    .db_hit(db_hit), .set_vec(set_vec), .mask(mask),
    .status(status), .irq(irq)
  );

  assert_mask_keeps_irq_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_wr && !db_hit) |=> $stable(irq));
endmodule

// File: tb/sim_msi_doorbell_ctrl.sv
module sim_msi_doorbell_ctrl;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        db_valid;
  logic [63:0] db_addr;
  logic [31:0] db_data;
  logic [3:0]  db_be;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_base;
  logic [31:0] m_en, m_mask, m_status;
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_doorbell_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
    .db_addr(db_addr), .db_data(db_data), .db_be(db_be), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] vbit(input logic [31:0] v);
    return (v < 32) ? (32'h1 << v[4:0]) : 32'h0;
  endfunction

  // Combined cycle: optional register write and optional doorbell write.
  task automatic cycle(input logic w, input logic [11:0] a, input logic [31:0] d,
                       input logic dv, input logic [63:0] da, input logic [31:0] dd,
                       input logic [3:0] be);
    logic hit, swr;
    logic [31:0] nxt;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    db_valid = dv; db_addr = da; db_data = dd; db_be = be;
    hit = dv && (da == m_base) && (be == 4'hF) && (m_en != 0);
    swr = w && (a == 12'h830);
    nxt = (m_status ^ (swr ? d : 32'h0)) | (hit ? (vbit(dd) & m_en) : 32'h0);
    if (hit && ((nxt & ~m_mask) != 0)) m_irq = 1'b1;
    else if (swr && nxt == 0) m_irq = 1'b0;
    if (hit || swr) m_status = nxt;
    if (w) begin
      if (a == 12'h820) m_base[31:0]  = d;
      if (a == 12'h824) m_base[63:32] = d;
      if (a == 12'h828) m_en   = d;
      if (a == 12'h82C) m_mask = d;
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0; db_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0, 64'h0, 32'h0, 4'h0);
  endtask

  task automatic db(input logic [63:0] da, input logic [31:0] dd, input logic [3:0] be);
    cycle(1'b0, 12'h0, 32'h0, 1'b1, da, dd, be);
  endtask

  task automatic state_chk(input string tag);
    read_chk({tag, " status"}, 12'h830, m_status);
    check({tag, " irq"}, {31'h0, irq}, {31'h0, m_irq});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    db_valid = 1'b0; db_addr = '0; db_data = '0; db_be = '0;
    m_base = '0; m_en = '0; m_mask = '0; m_status = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1: reset values and unmapped offsets
    read_chk("R1 lo", 12'h820, 0);
    read_chk("R1 hi", 12'h824, 0);
    read_chk("R1 en", 12'h828, 0);
    read_chk("R1 mask", 12'h82C, 0);
    read_chk("R1 status", 12'h830, 0);
    read_chk("R1 unmapped 834", 12'h834, 0);
    read_chk("R1 unmapped 000", 12'h000, 0);
    read_chk("R1 unmapped 81C", 12'h81C, 0);
    check("R1 irq", {31'h0, irq}, 0);

    // R2: half replacement
    wr(12'h820, 32'hFEE0_1000);
    wr(12'h824, 32'h0000_00A5);
    read_chk("R2 lo", 12'h820, 32'hFEE0_1000);
    read_chk("R2 hi", 12'h824, 32'h0000_00A5);
    wr(12'h820, 32'hFEE0_2000);
    read_chk("R2 hi kept", 12'h824, 32'h0000_00A5);
    read_chk("R2 lo new", 12'h820, 32'hFEE0_2000);

    // R4: enable zero ignores doorbell
    db(m_base, 32'd3, 4'hF);
    state_chk("R4 enable zero");

    // R3: enable and mask readback
    wr(12'h82C, 32'h1234_5678);
    read_chk("R3 mask", 12'h82C, 32'h1234_5678);
    wr(12'h82C, 32'h0);
    wr(12'h828, 32'hFFFF_FFFF);
    read_chk("R3 enable", 12'h828, 32'hFFFF_FFFF);

    // R5 R6 R7: sweep every vector 0..39, all enabled, nothing masked
    for (int v = 0; v < 40; v++) begin
      db(m_base, v, 4'hF);
      state_chk($sformatf("R5 R6 vector %0d", v));
      wr(12'h830, m_status);
      state_chk($sformatf("R7 clear vector %0d", v));
    end

    // R4: near misses
    db(m_base ^ 64'h4, 32'd1, 4'hF);
    state_chk("R4 low addr miss");
    db(m_base ^ 64'h1_0000_0000, 32'd1, 4'hF);
    state_chk("R4 high addr miss");
    for (int b = 0; b < 15; b++) begin
      db(m_base, 32'd2, b[3:0]);
      state_chk($sformatf("R4 strobe %0h", b));
    end
    cycle(1'b0, 12'h0, 32'h0, 1'b0, m_base, 32'd1, 4'hF);
    state_chk("R4 valid low");

    // R5 R6: partial enable and mask patterns
    wr(12'h828, 32'hA5A5_0F0F);
    wr(12'h82C, 32'hFFFF_0000);
    for (int v = 0; v < 32; v++) begin
      db(m_base, v, 4'hF);
      state_chk($sformatf("R5 R6 pattern vector %0d", v));
      wr(12'h830, m_status);
      state_chk($sformatf("R7 pattern clear %0d", v));
    end

    // R8: mask changes keep irq
    wr(12'h82C, 32'h0);
    db(m_base, 32'd0, 4'hF);
    state_chk("R8 setup high");
    wr(12'h82C, 32'hFFFF_FFFF);
    state_chk("R8 mask all keeps high");
    wr(12'h830, 32'h1);
    state_chk("R8 cleared");
    db(m_base, 32'd1, 4'hF);
    state_chk("R8 masked hit stays low");
    wr(12'h82C, 32'h0);
    state_chk("R8 unmask stays low");
    wr(12'h830, 32'h2);

    // R7: partial clear keeps irq
    db(m_base, 32'd8, 4'hF);
    db(m_base, 32'd9, 4'hF);
    wr(12'h830, 32'h100);
    state_chk("R7 partial clear");
    wr(12'h830, 32'h200);
    state_chk("R7 final clear");

    // R9: same-edge status write and doorbell
    db(m_base, 32'd3, 4'hF);
    cycle(1'b1, 12'h830, 32'h8, 1'b1, m_base, 32'd3, 4'hF);
    state_chk("R9 toggle then set same bit");
    cycle(1'b1, 12'h830, 32'h8, 1'b1, m_base, 32'd10, 4'hF);
    state_chk("R9 clear one set other");
    check("R9 status value", m_status, 32'h400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule